// File: doc/BRIEF.md
# Flash Warm-Reset Recovery Sequencer

This block sits on the host side of a single-line SPI link to a serial NOR flash that has no hardware reset pin. After a warm system reset, the flash may still be in a mode it was left in before the reset. One such mode is a continuous read, where it expects no opcode. Another is wrapped burst reads. When `start` is pulsed, the sequencer plays a fixed recovery script on the chip-select, serial-clock and data-out pins.

The script has up to four commands, in this order:
- an all-ones 16-bit exit pattern, which releases continuous read;
- a burst-wrap configuration command whose wrap byte disables wrapping;
- optionally, the enable-reset opcode;
- optionally, the reset opcode.

Each command is framed by its own chip-select assertion. The frames use SPI mode 0 and are sent MSB first.

The sequencer applies two start-up waits, both counted in system-clock cycles by internal timers. The first is a delay after `start` before chip select may first go low. The second is a longer delay before any write-class command may be sent. Between frames it keeps chip select high for a minimum number of cycles. The minimum is larger after a write-class command than after the read-class exit pattern. The same write-class gap is also held before `done` is raised. `busy` covers the whole script, and `done` marks its end.

Top module: `flash_recover_seq`

## Requirements
- R1: While reset is asserted and after it is released, `cs_n`=1, `sck`=0, `busy`=0 and `done`=0 until `start` is seen. Asserting reset during a script abandons it and returns the outputs to this state.
- R2: In idle, a `start` pulse raises `busy` on the next clock edge. A `start` seen while `busy` is high is ignored: the script is not restarted and no extra frame or `done` results.
- R3: The first frame is 16 clocks, all with data 1 (0xFFFF).
- R4: The second frame is 40 clocks and carries, in order:
  - opcode 0x77;
  - three filler bytes 0xFF;
  - the wrap byte 0xFF, in which bit 4 (wrap-disable) is forced to 1 and the don't-care bits are 1.
- R5: `sw_reset_en` is captured with `start`. When it is 1, two 8-clock frames follow: 0x66, then 0x99. When it is 0, the script ends after the wrap frame.
- R6: Frames use SPI mode 0:
  - `sck` is 0 whenever `cs_n` is 1;
  - `cs_n` never changes while `sck` is 1;
  - `mosi` is stable while `sck` is 1;
  - the device samples `mosi` on each `sck` rising edge, MSB first.
- R7: The first falling edge of `cs_n` comes at least `VSL_CYC` cycles after the cycle in which `start` was sampled.
- R8: No write-class frame (wrap, enable-reset or reset) asserts `cs_n` earlier than `PUW_CYC` cycles after `start` was sampled.
- R9: `cs_n` stays high for at least `GAP_RD_CYC` cycles after the exit-pattern frame. It stays high for at least `GAP_WR_CYC` cycles after every write-class frame. `done` comes no earlier than `GAP_WR_CYC` cycles after the last frame's `cs_n` rises.
- R10: `done` is high for exactly one cycle. It is high in the cycle in which `busy` has just fallen, and there is exactly one `done` per accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to launch the recovery script |
| sw_reset_en | input | 1 | Append the software-reset pair (captured with start) |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | SPI serial clock, idles low |
| mosi | output | 1 | Serial data to the flash |
| busy | output | 1 | High while the script runs |
| done | output | 1 | One-cycle pulse at the end of the script |

## Verification
The start-up waits and deselect gaps are measured as cycle counts between observed pin events:
- from the `start` sampling edge to a `cs_n` fall;
- from a `cs_n` rise to the next `cs_n` fall, or to `done`.

Each count is compared against its minimum. The design itself adds two to three cycles of register latency to every wait, so the checks use minimum bounds rather than exact cycle counts.

Frame contents are rebuilt at the pins. The bench shifts in `mosi` on every observed `sck` rise while `cs_n` is low, and closes a frame when `cs_n` rises. It compares each frame's length and value only once the frame has closed. All outputs are sampled on the falling clock edge, half a cycle after the registers update.

// File: rtl/frs_pkg.sv
package frs_pkg;

  localparam int FRAME_MAX = 40;
  localparam int NBW       = $clog2(FRAME_MAX + 1);

  typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT, SQ_SHIFT, SQ_TAIL} seq_state_e;
  typedef enum logic [1:0] {SH_IDLE, SH_LO, SH_HI, SH_HOLD} shf_state_e;

  typedef struct packed {
    logic [NBW-1:0]       nbits;
    logic                 wr_class;
    logic [FRAME_MAX-1:0] bits;     // left aligned, MSB goes first
  } cmd_t;

  // wrap byte: bit 4 disables wrapping and is forced high, rest don't care -> 1
  localparam logic [7:0] WRAP_CFG = 8'hEF | 8'h10;

  function automatic cmd_t cmd_for_step(input logic [1:0] stp);
    cmd_t c;
    case (stp)
      2'd0: c = '{nbits: NBW'(16), wr_class: 1'b0, bits: {16'hFFFF, 24'h0}};
      2'd1: c = '{nbits: NBW'(40), wr_class: 1'b1, bits: {8'h77, 24'hFFFFFF, WRAP_CFG}};
      2'd2: c = '{nbits: NBW'(8),  wr_class: 1'b1, bits: {8'h66, 32'h0}};
      default: c = '{nbits: NBW'(8), wr_class: 1'b1, bits: {8'h99, 32'h0}};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/frs_timer.sv
module frs_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/frs_shifter.sv
module frs_shifter
  import frs_pkg::*;
#(
  parameter int SCK_HALF = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic [FRAME_MAX-1:0] frame,
  input  logic [NBW-1:0]       nbits,
  output logic                 cs_n,
  output logic                 sck,
  output logic                 mosi,
  output logic                 fdone
);
  localparam int HCW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam logic [HCW-1:0] HALF_LD = HCW'(SCK_HALF - 1);

  shf_state_e           st;
  logic [HCW-1:0]       hc;
  logic [FRAME_MAX-1:0] sr;
  logic [NBW-1:0]       left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SH_IDLE;
      hc    <= '0;
      sr    <= '0;
      left  <= '0;
      cs_n  <= 1'b1;
      sck   <= 1'b0;
      fdone <= 1'b0;
    end else begin
      fdone <= 1'b0;
      case (st)
        SH_IDLE: if (go) begin
          cs_n <= 1'b0;
          sr   <= frame;
          left <= nbits;
          hc   <= HALF_LD;
          st   <= SH_LO;
        end
        SH_LO: begin
          if (hc == '0) begin
            sck <= 1'b1;
            hc  <= HALF_LD;
            st  <= SH_HI;
          end else hc <= hc - 1'b1;
        end
        SH_HI: begin
          if (hc == '0) begin
            sck <= 1'b0;
            hc  <= HALF_LD;
            if (left == NBW'(1)) st <= SH_HOLD;
            else begin
              sr   <= sr << 1;
              left <= left - 1'b1;
              st   <= SH_LO;
            end
          end else hc <= hc - 1'b1;
        end
        SH_HOLD: begin
          if (hc == '0) begin
            cs_n  <= 1'b1;
            fdone <= 1'b1;
            sr    <= '0;
            st    <= SH_IDLE;
          end else hc <= hc - 1'b1;
        end
        default: st <= SH_IDLE;
      endcase
    end
  end

  assign mosi = sr[FRAME_MAX-1];
endmodule

// File: rtl/frs_ctrl.sv
module frs_ctrl
  import frs_pkg::*;
#(
  parameter int VSL_CYC    = 1250,
  parameter int PUW_CYC    = 625000,
  parameter int GAP_RD_CYC = 1,
  parameter int GAP_WR_CYC = 5,
  parameter int TW         = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          sw_reset_en,
  input  logic          gap_exp,
  input  logic          puw_exp,
  input  logic          fdone,
  output logic          gap_load,
  output logic [TW-1:0] gap_val,
  output logic          puw_load,
  output logic [TW-1:0] puw_val,
  output logic          go,
  output cmd_t          cmd,
  output logic          busy,
  output logic          done
);
  seq_state_e st;
  logic [1:0] stp;
  logic       sw_q;
  logic       last_step;
  logic       may_send;

  assign cmd       = cmd_for_step(stp);
  assign last_step = sw_q ? (stp == 2'd3) : (stp == 2'd1);
  assign may_send  = gap_exp && (!cmd.wr_class || puw_exp);
  assign go        = (st == SQ_WAIT) && may_send;
  assign puw_load  = (st == SQ_IDLE) && start;
  assign puw_val   = TW'(PUW_CYC);

  always_comb begin
    gap_load = 1'b0;
    gap_val  = TW'(VSL_CYC);
    if (st == SQ_IDLE && start) gap_load = 1'b1;
    else if (st == SQ_SHIFT && fdone) begin
      gap_load = 1'b1;
      gap_val  = cmd.wr_class ? TW'(GAP_WR_CYC) : TW'(GAP_RD_CYC);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= SQ_IDLE;
      stp  <= 2'd0;
      sw_q <= 1'b0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        SQ_IDLE: if (start) begin
          busy <= 1'b1;
          stp  <= 2'd0;
          sw_q <= sw_reset_en;
          st   <= SQ_WAIT;
        end
        SQ_WAIT: if (go) st <= SQ_SHIFT;
        SQ_SHIFT: if (fdone) begin
          if (last_step) st <= SQ_TAIL;
          else begin
            stp <= stp + 2'd1;
            st  <= SQ_WAIT;
          end
        end
        SQ_TAIL: if (gap_exp) begin
          busy <= 1'b0;
          done <= 1'b1;
          st   <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_recover_seq.sv
module flash_recover_seq
  import frs_pkg::*;
#(
  parameter int SCK_HALF   = 1,
  parameter int VSL_CYC    = 1250,
  parameter int PUW_CYC    = 625000,
  parameter int GAP_RD_CYC = 1,
  parameter int GAP_WR_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sw_reset_en,
  output logic cs_n,
  output logic sck,
  output logic mosi,
  output logic busy,
  output logic done
);
  localparam int MAXW = (PUW_CYC > VSL_CYC) ? PUW_CYC : VSL_CYC;
  localparam int TW   = $clog2(MAXW + 1);

  logic          gap_load, puw_load, gap_exp, puw_exp, go, fdone;
  logic [TW-1:0] gap_val, puw_val;
  cmd_t          cmd;

  frs_ctrl #(
    .VSL_CYC(VSL_CYC), .PUW_CYC(PUW_CYC),
    .GAP_RD_CYC(GAP_RD_CYC), .GAP_WR_CYC(GAP_WR_CYC), .TW(TW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .sw_reset_en(sw_reset_en),
    .gap_exp(gap_exp), .puw_exp(puw_exp), .fdone(fdone),
    .gap_load(gap_load), .gap_val(gap_val),
    .puw_load(puw_load), .puw_val(puw_val),
    .go(go), .cmd(cmd), .busy(busy), .done(done)
  );

  frs_timer #(.W(TW)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(gap_val), .expired(gap_exp)
  );

  frs_timer #(.W(TW)) u_puw (
    .clk(clk), .rst_n(rst_n), .load(puw_load), .load_val(puw_val), .expired(puw_exp)
  );

  frs_shifter #(.SCK_HALF(SCK_HALF)) u_shf (
    .clk(clk), .rst_n(rst_n), .go(go), .frame(cmd.bits), .nbits(cmd.nbits),
    .cs_n(cs_n), .sck(sck), .mosi(mosi), .fdone(fdone)
  );
endmodule

// File: rtl/flash_recover_seq_chk.sv
module flash_recover_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sck,
  input logic mosi,
  input logic busy,
  input logic done
);
  // R1: chip select stays high outside a running script
  a_r1_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);

  // R6: clock idles low while deselected
  a_r6_sck_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R6: data held while clock high
  a_r6_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  // R6: chip select does not move while clock high
  a_r6_cs_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(cs_n));

  // R10: done is a single-cycle pulse
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: done coincides with busy having just dropped
  a_r10_done_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!busy && $past(busy)));
endmodule

bind flash_recover_seq flash_recover_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
  .busy(busy), .done(done)
);

// File: tb/tb_flash_recover_seq.sv
module tb_flash_recover_seq;
  localparam int SCK_HALF = 2;
  localparam int VSL      = 20;
  localparam int PUW      = 300;
  localparam int GRD      = 3;
  localparam int GWR      = 6;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sw_en = 1'b0;
  logic cs_n, sck, mosi, busy, done;

  always #4 clk = ~clk;

  flash_recover_seq #(
    .SCK_HALF(SCK_HALF), .VSL_CYC(VSL), .PUW_CYC(PUW),
    .GAP_RD_CYC(GRD), .GAP_WR_CYC(GWR)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sw_reset_en(sw_en),
    .cs_n(cs_n), .sck(sck), .mosi(mosi), .busy(busy), .done(done)
  );

  localparam int NV = 4;
  localparam int          EXP_NB [NV] = '{16, 40, 8, 8};
  localparam logic [39:0] EXP_D  [NV] = '{40'hFFFF, 40'h77FFFFFFFF, 40'h66, 40'h99};
  localparam int          EXP_GAP[NV] = '{VSL, GRD, GWR, GWR};

  int nchk = 0, nfail = 0;
  int cyc = 0, start_cyc = 0, last_rise = 0;
  int nf = 0, ndone = 0, done_cyc = 0, viol = 0;
  int fnb [8];
  logic [39:0] fdat [8];
  int fgap[8], ffall[8];
  int cur_nb = 0;
  logic [39:0] cur_d = '0;
  logic p_cs = 1'b1, p_sck = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp_v);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  // pin monitor at the falling edge
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (!cs_n && !busy) viol <= viol + 1;
      if (cs_n && sck) viol <= viol + 1;
      if (p_cs && !cs_n && nf < 8) begin
        ffall[nf] <= cyc;
        fgap[nf]  <= cyc - last_rise;
        cur_nb = 0;
        cur_d  = '0;
      end
      if (!cs_n && sck && !p_sck) begin
        cur_d  = {cur_d[38:0], mosi};
        cur_nb = cur_nb + 1;
      end
      if (!p_cs && cs_n && nf < 8) begin
        fnb[nf]  <= cur_nb;
        fdat[nf] <= cur_d;
        nf       <= nf + 1;
        last_rise <= cyc;
      end
      if (done) begin
        ndone    <= ndone + 1;
        done_cyc <= cyc;
      end
    end
    p_cs  <= cs_n;
    p_sck <= sck;
  end

  task automatic clear_log();
    @(negedge clk);
    nf = 0; ndone = 0; viol = 0;
  endtask

  task automatic pulse_start(input logic en);
    @(negedge clk);
    start = 1'b1; sw_en = en;
    start_cyc = cyc;
    last_rise = cyc;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2 busy after start", busy, 1);
  endtask

  task automatic wait_done();
    int t = 0;
    while (ndone == 0 && t < 5000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #600000;
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n === 1 && sck === 0 && busy === 0 && done === 0, "R1 in reset",
        {cs_n, sck, busy, done}, 4'b1000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cs_n === 1 && sck === 0 && busy === 0 && done === 0, "R1 after release",
        {cs_n, sck, busy, done}, 4'b1000);

    // full script, walked from the vector table (R3 R4 R5 R7 R9)
    clear_log();
    pulse_start(1'b1);
    wait_done();
    chk(nf == NV, "R5 frame count with reset pair", nf, NV);
    for (int i = 0; i < NV; i++) begin
      chk(fnb[i] == EXP_NB[i], "R3/R4/R5 frame length", fnb[i], EXP_NB[i]);
      chk(fdat[i] == EXP_D[i], "R3/R4/R5 frame value", fdat[i], EXP_D[i]);
      chk(fgap[i] >= EXP_GAP[i], "R7/R9 deselect gap", fgap[i], EXP_GAP[i]);
    end
    chk(fgap[0] >= VSL, "R7 first select delay", fgap[0], VSL);
    for (int i = 1; i < NV; i++)
      chk(ffall[i] - start_cyc >= PUW, "R8 write-class after power-up wait",
          ffall[i] - start_cyc, PUW);
    chk(done_cyc - last_rise >= GWR, "R9 tail gap before done", done_cyc - last_rise, GWR);
    chk(ndone == 1, "R10 one done per start", ndone, 1);
    chk(busy === 0, "R10 busy low after done", busy, 0);
    chk(viol == 0, "R6 mode-0 framing", viol, 0);

    // R5 without the reset pair
    clear_log();
    pulse_start(1'b0);
    wait_done();
    chk(nf == 2, "R5 frame count without reset pair", nf, 2);
    chk(fdat[1] == EXP_D[1] && fnb[1] == 40, "R4 wrap frame", fdat[1], EXP_D[1]);
    chk(ndone == 1, "R10 done without reset pair", ndone, 1);

    // R2 start during busy is ignored
    clear_log();
    pulse_start(1'b1);
    repeat (100) @(negedge clk);
    start = 1'b1; sw_en = 1'b0;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    repeat (PUW + 50) @(negedge clk);
    chk(nf == NV, "R2 restart ignored frames", nf, NV);
    chk(ndone == 1, "R2 restart ignored done", ndone, 1);

    // R1 reset mid-script
    clear_log();
    pulse_start(1'b1);
    repeat (VSL + 10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(cs_n === 1 && sck === 0 && busy === 0, "R1 reset mid-script",
        {cs_n, sck, busy}, 3'b100);
    rst_n = 1'b1;
    repeat (50) @(negedge clk);
    chk(cs_n === 1 && busy === 0 && done === 0, "R1 stays idle after reset",
        {cs_n, busy, done}, 3'b100);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule